// File: doc/BRIEF.md
# Proximity Card Command Controller

This block is the command layer of a passive proximity card that speaks the ISO/IEC 14443 Type A protocol. A frame receiver hands it each decoded reader frame as a command byte, one argument byte and a 32-bit identifier field, qualified by a one-cycle valid strobe. From these frames the controller moves the card through its life cycle. The card leaves power-on sleep when it is woken. It takes part in bit-oriented anticollision, where it returns only the identifier bits the reader has not yet sent. It becomes the selected card when its full identifier is named. It can then be parked by a halt.

Once selected, the card asks an external cipher engine to authenticate a sector. The engine reports the result on a done/ok strobe pair. The controller grants or denies each memory command against the sector that was authenticated, and it always protects the manufacturer block. Responses leave as a request to a frame transmitter: a valid pulse, a right-aligned data word and a bit count.

Top module: `cardProtoCtl`

## Requirements
- R1: After reset the state output is sleep (0), and txValid, memGrant and memDeny are low.
- R2: In sleep (0), a frame with command 0x26 or 0x52 produces one response of 16 bits, with txData equal to the ATQA parameter (default 0x0002), and the state becomes ready (1). Every other frame in sleep is ignored, with no response and no state change.
- R3: In halted (5), only command 0x52 is answered: it gives the ATQA response and the state becomes ready (1). Any other frame leaves the state at 5 with no response.
- R4: In ready (1), command 0x93 with an argument other than 0x70 is an anticollision frame. The argument is upper nibble B and lower nibble b, and k = 8*(B-2)+b counts the identifier bits already sent. The argument is valid when B>=2, b<=7 and k<32. When bits k-1..0 of rxUid (bit 0 is sent first) equal the same bits of cardUid, the card answers with txData = cardUid >> k and txBits = 32-k. Otherwise it stays silent in state 1.
- R5: In ready (1), command 0x93 with argument 0x70 and rxUid equal to cardUid makes the state active (2) and answers with 8 bits, txData equal to the SAK parameter (default 0x18).
- R6: A select that does not match, an anticollision argument that is not valid, or any command not listed for the current state sends the card from states 1 to 4 back to its fallback state. The fallback state is halted (5) if the card was last woken by 0x52 from halted, and sleep (0) otherwise. Authentication is cleared.
- R7: Command 0x50 in active (2) or authenticated (4) moves the card to halted (5) with no response.
- R8: Command 0x60 or 0x61 with a block address in active (2) or authenticated (4) moves the card to waiting (3) and records that block's sector. A following authDone with authOk high moves it to authenticated (4). With authOk low, the card goes to its fallback state.
- R9: The memory commands are 0x30, 0xA0, 0xC0, 0xC1, 0xC2 and 0xB0, and each takes a block address as its argument. Such a command gives memGrant only in authenticated (4) and only when the block lies in the recorded sector. The sector is block/4 for blocks 0 to 127 and 32+(block-128)/16 for blocks 128 to 255.
- R10: A memory command in states 1, 2 or 3, or in state 4 addressing another sector, gives memDeny and sends the card to its fallback state. In states 0 and 5 it is ignored.
- R11: In authenticated (4), command 0xA0 or 0xB0 to block 0 gives memDeny and the card stays in state 4. Other memory commands to block 0 are granted when sector 0 is authenticated.
- R12: txValid, memGrant and memDeny are registered one-cycle pulses. They are asserted in the cycle after the frame's valid cycle and are low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe marking a decoded reader frame |
| rxCmd | input | 8 | Command byte of the frame |
| rxArg | input | 8 | Argument byte: bit count for anticollision, block address otherwise |
| rxUid | input | 32 | Identifier field of the frame, bit 0 first on air |
| cardUid | input | 32 | This card's identifier |
| authDone | input | 1 | Strobe: the cipher engine finished an authentication |
| authOk | input | 1 | Result qualifying authDone |
| txValid | output | 1 | Response request pulse to the transmitter |
| txData | output | 32 | Response bits, right-aligned |
| txBits | output | 6 | Number of valid response bits |
| memGrant | output | 1 | Pulse: the memory command may proceed |
| memDeny | output | 1 | Pulse: the memory command is refused |
| cardState | output | 3 | Protocol state: 0 sleep, 1 ready, 2 active, 3 waiting, 4 authenticated, 5 halted |

## Verification
A wrong internal state appears at the ports within one frame, because every frame produces either a registered pulse or a state code in the next cycle. A corrupted remembered sector or halt origin stays hidden until the next memory command or fallback. For that reason the bench sweeps every block address through authenticate, grant and cross-sector deny, and it repeats fallbacks from both sleep and halted. A bit-count decode error shows up as a wrong tail length or a wrong tail value for one of the 32 prefix lengths. All 32 lengths are swept with unknown bits scrambled and the last known bit flipped.

// File: rtl/cardProtoPkg.sv
package cardProtoPkg;

  typedef enum logic [2:0] {
    ST_SLEEP    = 3'd0,
    ST_READY    = 3'd1,
    ST_ACTIVE   = 3'd2,
    ST_AUTHWAIT = 3'd3,
    ST_AUTHED   = 3'd4,
    ST_HALTED   = 3'd5
  } cardState_t;

  localparam logic [7:0] CMD_REQ      = 8'h26;
  localparam logic [7:0] CMD_WAKE     = 8'h52;
  localparam logic [7:0] CMD_CASCADE  = 8'h93;
  localparam logic [7:0] CMD_HALT     = 8'h50;
  localparam logic [7:0] CMD_AUTH_A   = 8'h60;
  localparam logic [7:0] CMD_AUTH_B   = 8'h61;
  localparam logic [7:0] CMD_READ     = 8'h30;
  localparam logic [7:0] CMD_WRITE    = 8'hA0;
  localparam logic [7:0] CMD_DEC      = 8'hC0;
  localparam logic [7:0] CMD_INC      = 8'hC1;
  localparam logic [7:0] CMD_RESTORE  = 8'hC2;
  localparam logic [7:0] CMD_TRANSFER = 8'hB0;
  localparam logic [7:0] ARG_SELECT   = 8'h70;

  // control -> datapath strobes
  typedef struct packed {
    logic sendAtqa;
    logic sendTail;
    logic sendSak;
    logic grant;
    logic deny;
    logic saveSector;
  } ctlStrobe_t;

  // datapath -> control qualifiers
  typedef struct packed {
    logic prefixMatch;
    logic fullMatch;
    logic argOk;
    logic sectorHit;
    logic protectedWrite;
  } dpFlags_t;

endpackage

// File: rtl/cardCtlData.sv
module cardCtlData
  import cardProtoPkg::*;
#(
  parameter int UID_W         = 32,
  parameter int ADDR_W        = 8,
  parameter int SMALL_SECTORS = 32,
  parameter int SMALL_BLOCKS  = 4,
  parameter int LARGE_BLOCKS  = 16,
  parameter logic [15:0] ATQA = 16'h0002,
  parameter logic [7:0]  SAK  = 8'h18,
  localparam int CNT_W        = $clog2(UID_W),
  localparam int TXB_W        = $clog2(UID_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxCmd,
  input  logic [ADDR_W-1:0] rxArg,
  input  logic [UID_W-1:0]  rxUid,
  input  logic [UID_W-1:0]  cardUid,
  input  ctlStrobe_t        strobe,
  output dpFlags_t          flags,
  output logic              txValid,
  output logic [UID_W-1:0]  txData,
  output logic [TXB_W-1:0]  txBits,
  output logic              memGrant,
  output logic              memDeny
);

  localparam int SMALL_SPAN    = SMALL_SECTORS * SMALL_BLOCKS;
  localparam int LARGE_SECTORS = ((1 << ADDR_W) > SMALL_SPAN)
                                 ? ((1 << ADDR_W) - SMALL_SPAN) / LARGE_BLOCKS : 0;
  localparam int SECT_W        = $clog2(SMALL_SECTORS + LARGE_SECTORS + 1);
  localparam int SB_SH         = $clog2(SMALL_BLOCKS);
  localparam int LB_SH         = $clog2(LARGE_BLOCKS);

  // bit-count decode of the anticollision argument
  logic [3:0]       argBytes, argBits;
  logic [8:0]       kWide;
  logic [CNT_W-1:0] knownBits;
  logic [UID_W-1:0] prefMask;

  always_comb begin
    argBytes  = rxArg[7:4];
    argBits   = rxArg[3:0];
    kWide     = {2'b00, argBytes, 3'b000} - 9'd16 + {5'd0, argBits};
    knownBits = CNT_W'(kWide);
    prefMask  = ~({UID_W{1'b1}} << knownBits);
  end

  assign flags.argOk       = (argBytes >= 4'd2) && (argBits <= 4'd7) && (kWide < 9'(UID_W));
  assign flags.prefixMatch = ((rxUid ^ cardUid) & prefMask) == '0;
  assign flags.fullMatch   = (rxUid == cardUid);

  // block -> sector decode; variant picked by the memory split
  logic [SECT_W-1:0] reqSector;
  logic [SECT_W-1:0] authSector;

  generate
    if (LARGE_SECTORS == 0) begin : gUniform
      assign reqSector = SECT_W'(rxArg >> SB_SH);
    end else begin : gSplit
      localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SMALL_SPAN);
      logic [ADDR_W-1:0] offset;
      assign offset    = rxArg - SPAN_A;
      assign reqSector = (rxArg < SPAN_A)
                         ? SECT_W'(rxArg >> SB_SH)
                         : SECT_W'(SMALL_SECTORS) + SECT_W'(offset >> LB_SH);
    end
  endgenerate

  assign flags.sectorHit      = (reqSector == authSector);
  assign flags.protectedWrite = (rxArg == '0) && ((rxCmd == CMD_WRITE) || (rxCmd == CMD_TRANSFER));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid    <= 1'b0;
      txData     <= '0;
      txBits     <= '0;
      memGrant   <= 1'b0;
      memDeny    <= 1'b0;
      authSector <= '0;
    end else begin
      txValid  <= strobe.sendAtqa | strobe.sendTail | strobe.sendSak;
      memGrant <= strobe.grant;
      memDeny  <= strobe.deny;
      if (strobe.saveSector) authSector <= reqSector;
      if (strobe.sendAtqa) begin
        txData <= UID_W'(ATQA);
        txBits <= TXB_W'(16);
      end else if (strobe.sendSak) begin
        txData <= UID_W'(SAK);
        txBits <= TXB_W'(8);
      end else if (strobe.sendTail) begin
        txData <= cardUid >> knownBits;
        txBits <= TXB_W'(UID_W) - TXB_W'(knownBits);
      end
    end
  end

endmodule

// File: rtl/cardCtlFsm.sv
module cardCtlFsm
  import cardProtoPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxCmd,
  input  logic [7:0] rxArg,
  input  logic       authDone,
  input  logic       authOk,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output cardState_t state
);

  cardState_t nxt, fallback;
  logic       wasHalted, nxtHalted;
  logic       isMem, isAuth;

  always_comb begin
    isMem  = (rxCmd == CMD_READ) || (rxCmd == CMD_WRITE) || (rxCmd == CMD_DEC) ||
             (rxCmd == CMD_INC)  || (rxCmd == CMD_RESTORE) || (rxCmd == CMD_TRANSFER);
    isAuth = (rxCmd == CMD_AUTH_A) || (rxCmd == CMD_AUTH_B);
    fallback  = wasHalted ? ST_HALTED : ST_SLEEP;
    nxt       = state;
    nxtHalted = wasHalted;
    strobe    = '0;
    case (state)
      ST_SLEEP: if (rxValid && (rxCmd == CMD_REQ || rxCmd == CMD_WAKE)) begin
        nxt = ST_READY;  strobe.sendAtqa = 1'b1;  nxtHalted = 1'b0;
      end
      ST_HALTED: if (rxValid && rxCmd == CMD_WAKE) begin
        nxt = ST_READY;  strobe.sendAtqa = 1'b1;  nxtHalted = 1'b1;
      end
      ST_READY: if (rxValid) begin
        if (rxCmd == CMD_CASCADE && rxArg == ARG_SELECT) begin
          if (flags.fullMatch) begin
            nxt = ST_ACTIVE;  strobe.sendSak = 1'b1;
          end else nxt = fallback;
        end else if (rxCmd == CMD_CASCADE && flags.argOk) begin
          strobe.sendTail = flags.prefixMatch;
        end else begin
          nxt = fallback;  strobe.deny = isMem;
        end
      end
      ST_ACTIVE: if (rxValid) begin
        if (rxCmd == CMD_HALT) nxt = ST_HALTED;
        else if (isAuth) begin
          nxt = ST_AUTHWAIT;  strobe.saveSector = 1'b1;
        end else begin
          nxt = fallback;  strobe.deny = isMem;
        end
      end
      ST_AUTHWAIT: begin
        if (rxValid) begin
          nxt = fallback;  strobe.deny = isMem;
        end else if (authDone) nxt = authOk ? ST_AUTHED : fallback;
      end
      ST_AUTHED: if (rxValid) begin
        if (rxCmd == CMD_HALT) nxt = ST_HALTED;
        else if (isAuth) begin
          nxt = ST_AUTHWAIT;  strobe.saveSector = 1'b1;
        end else if (isMem) begin
          if (!flags.sectorHit) begin
            nxt = fallback;  strobe.deny = 1'b1;
          end else if (flags.protectedWrite) strobe.deny = 1'b1;
          else strobe.grant = 1'b1;
        end else nxt = fallback;
      end
      default: nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_SLEEP;
      wasHalted <= 1'b0;
    end else begin
      state     <= nxt;
      wasHalted <= nxtHalted;
    end
  end

endmodule

// File: rtl/cardProtoCtl.sv
module cardProtoCtl
  import cardProtoPkg::*;
#(
  parameter logic [15:0] ATQA = 16'h0002,
  parameter logic [7:0]  SAK  = 8'h18,
  parameter int SMALL_SECTORS = 32,
  parameter int SMALL_BLOCKS  = 4,
  parameter int LARGE_BLOCKS  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxCmd,
  input  logic [7:0]  rxArg,
  input  logic [31:0] rxUid,
  input  logic [31:0] cardUid,
  input  logic        authDone,
  input  logic        authOk,
  output logic        txValid,
  output logic [31:0] txData,
  output logic [5:0]  txBits,
  output logic        memGrant,
  output logic        memDeny,
  output logic [2:0]  cardState
);

  ctlStrobe_t strobe;
  dpFlags_t   flags;
  cardState_t state;

  cardCtlFsm u_fsm (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxCmd(rxCmd), .rxArg(rxArg),
    .authDone(authDone), .authOk(authOk), .flags(flags), .strobe(strobe), .state(state)
  );

  cardCtlData #(
    .UID_W(32), .ADDR_W(8), .SMALL_SECTORS(SMALL_SECTORS), .SMALL_BLOCKS(SMALL_BLOCKS),
    .LARGE_BLOCKS(LARGE_BLOCKS), .ATQA(ATQA), .SAK(SAK)
  ) u_data (
    .clk(clk), .rstN(rstN), .rxCmd(rxCmd), .rxArg(rxArg), .rxUid(rxUid),
    .cardUid(cardUid), .strobe(strobe), .flags(flags), .txValid(txValid),
    .txData(txData), .txBits(txBits), .memGrant(memGrant), .memDeny(memDeny)
  );

  assign cardState = state;

endmodule

// File: rtl/cardProtoCtlChk.sv
module cardProtoCtlChk #(
  parameter logic [15:0] ATQA = 16'h0002
) (
  input logic        clk,
  input logic        rstN,
  input logic        rxValid,
  input logic [7:0]  rxCmd,
  input logic [7:0]  rxArg,
  input logic        authDone,
  input logic        authOk,
  input logic        txValid,
  input logic [31:0] txData,
  input logic [5:0]  txBits,
  input logic        memGrant,
  input logic        memDeny,
  input logic [2:0]  cardState
);

  AST_SLEEP_ANSWERS_ATQA: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cardState) == 3'd0 && txValid) |-> (txBits == 6'd16 && txData == {16'd0, ATQA})); // R2

  AST_HALT_ONLY_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cardState) == 3'd5 && !($past(rxValid) && $past(rxCmd) == 8'h52))
      |-> (cardState == 3'd5 && !txValid)); // R3

  AST_SAK_MEANS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txBits == 6'd8 && $past(rxArg) == 8'h70) |-> cardState == 3'd2); // R5

  AST_AUTH_FAIL_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cardState) == 3'd3 && $past(authDone) && !$past(authOk) && !$past(rxValid))
      |-> (cardState == 3'd0 || cardState == 3'd5)); // R8

  AST_GRANT_NEEDS_AUTH: assert property (@(posedge clk) disable iff (!rstN)
    memGrant |-> ($past(cardState) == 3'd4 && cardState == 3'd4)); // R9

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memGrant && memDeny)); // R10

  AST_BLOCK0_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memGrant |-> !($past(rxArg) == 8'h00 && ($past(rxCmd) == 8'hA0 || $past(rxCmd) == 8'hB0))); // R11

endmodule

bind cardProtoCtl cardProtoCtlChk #(.ATQA(ATQA)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxCmd(rxCmd), .rxArg(rxArg),
  .authDone(authDone), .authOk(authOk), .txValid(txValid), .txData(txData),
  .txBits(txBits), .memGrant(memGrant), .memDeny(memDeny), .cardState(cardState)
);

// File: tb/cardProtoCtl_bench.sv
module cardProtoCtl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxCmd = '0;
  logic [7:0]  rxArg = '0;
  logic [31:0] rxUid = '0;
  logic [31:0] cardUid = 32'hA53C96E1;
  logic        authDone = 1'b0;
  logic        authOk = 1'b0;
  logic        txValid, memGrant, memDeny;
  logic [31:0] txData;
  logic [5:0]  txBits;
  logic [2:0]  cardState;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cardProtoCtl u_cardProtoCtl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxCmd(rxCmd), .rxArg(rxArg),
    .rxUid(rxUid), .cardUid(cardUid), .authDone(authDone), .authOk(authOk),
    .txValid(txValid), .txData(txData), .txBits(txBits), .memGrant(memGrant),
    .memDeny(memDeny), .cardState(cardState)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one frame; on return outputs reflect it (one register stage)
  task automatic frame(input logic [7:0] c, input logic [7:0] a, input logic [31:0] u);
    @(negedge clk);
    rxValid = 1'b1; rxCmd = c; rxArg = a; rxUid = u;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic authPulse(input logic ok);
    @(negedge clk);
    authDone = 1'b1; authOk = ok;
    @(negedge clk);
    authDone = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic bringUp();
    frame(8'h26, 8'h00, 32'h0);
    frame(8'h93, 8'h70, cardUid);
  endtask

  function automatic int sectorOf(input int b);
    return (b < 128) ? b / 4 : 32 + (b - 128) / 16;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] grantCmds [4];
    grantCmds[0] = 8'h30; grantCmds[1] = 8'hC1; grantCmds[2] = 8'hC0; grantCmds[3] = 8'hA0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 state", 64'(cardState), 64'd0);
    chk("R1 quiet", {61'd0, txValid, memGrant, memDeny}, 64'd0);
    rstN = 1'b1;

    // R2 sleep ignores other commands, answers request
    frame(8'h93, 8'h20, 32'h0);
    chk("R2 ignore tx", 64'(txValid), 64'd0);
    chk("R2 ignore state", 64'(cardState), 64'd0);
    frame(8'h26, 8'h00, 32'h0);
    chk("R2 atqa", {txValid, txBits, txData}, {1'b1, 6'd16, 32'h0002});
    chk("R2 ready", 64'(cardState), 64'd1);
    @(negedge clk);
    chk("R12 pulse ends", 64'(txValid), 64'd0);

    // R4 anticollision sweep over every prefix length, two identifiers
    for (int n = 0; n < 2; n++) begin
      doReset();
      cardUid = (n == 0) ? 32'hA53C96E1 : 32'h5A0F3C81;
      frame(8'h52, 8'h00, 32'h0);
      for (int k = 0; k < 32; k++) begin
        logic [31:0] mask;
        logic [7:0]  nvb;
        mask = (k == 0) ? 32'h0 : (32'hFFFFFFFF >> (32 - k));
        nvb  = {4'(k / 8 + 2), 4'(k % 8)};
        frame(8'h93, nvb, cardUid ^ ~mask);
        chk("R4 tail", {txValid, txBits, txData}, {1'b1, 6'(32 - k), cardUid >> k});
        if (k > 0) begin
          frame(8'h93, nvb, cardUid ^ (32'h1 << (k - 1)));
          chk("R4 mismatch silent", 64'(txValid), 64'd0);
          chk("R4 stay ready", 64'(cardState), 64'd1);
        end
      end
    end

    // R6 invalid bit count falls back to sleep
    frame(8'h93, 8'h28, cardUid);
    chk("R6 bad arg", 64'(cardState), 64'd0);

    // R6 select mismatch, R5 select match
    frame(8'h26, 8'h00, 32'h0);
    frame(8'h93, 8'h70, cardUid ^ 32'h0001_0000);
    chk("R6 select miss", {61'd0, txValid, cardState}, 64'd0);
    bringUp();
    chk("R5 sak", {txValid, txBits, txData}, {1'b1, 6'd8, 32'h18});
    chk("R5 active", 64'(cardState), 64'd2);

    // R10 memory command before authentication
    frame(8'h30, 8'h04, 32'h0);
    chk("R10 deny unauth", {memGrant, memDeny}, 2'b01);
    chk("R10 fallback", 64'(cardState), 64'd0);
    frame(8'h30, 8'h04, 32'h0);
    chk("R10 sleep ignores", {61'd0, memGrant, memDeny, txValid}, 64'd0);

    // R9 / R10 sweep of every block address
    for (int b = 0; b < 256; b++) begin
      bringUp();
      frame(8'h60 | 8'(b & 1), 8'(b), 32'h0);
      chk("R8 wait", 64'(cardState), 64'd3);
      authPulse(1'b1);
      chk("R8 authed", 64'(cardState), 64'd4);
      frame((b == 0) ? 8'h30 : grantCmds[b % 4], 8'(b), 32'h0);
      chk($sformatf("R9 grant blk %0d sector %0d", b, sectorOf(b)), {memGrant, memDeny}, 2'b10);
      frame(8'hC2, 8'((b + 128) % 256), 32'h0);
      chk("R10 other sector", {memGrant, memDeny, cardState}, {2'b01, 3'd0});
    end

    // R9 sector boundaries within the split
    bringUp();
    frame(8'h61, 8'd127, 32'h0); authPulse(1'b1);
    frame(8'h30, 8'd124, 32'h0);
    chk("R9 same small sector", {memGrant, memDeny}, 2'b10);
    frame(8'h30, 8'd128, 32'h0);
    chk("R9 boundary 128", {memGrant, memDeny, cardState}, {2'b01, 3'd0});

    // R11 manufacturer block
    bringUp();
    frame(8'h60, 8'd3, 32'h0); authPulse(1'b1);
    frame(8'hA0, 8'd0, 32'h0);
    chk("R11 write blk0", {memGrant, memDeny, cardState}, {2'b01, 3'd4});
    frame(8'hB0, 8'd0, 32'h0);
    chk("R11 transfer blk0", {memGrant, memDeny, cardState}, {2'b01, 3'd4});
    frame(8'h30, 8'd0, 32'h0);
    chk("R11 read blk0", {memGrant, memDeny}, 2'b10);
    frame(8'hA0, 8'd1, 32'h0);
    chk("R11 write blk1", {memGrant, memDeny}, 2'b10);

    // R8 re-authentication moves to another sector
    frame(8'h60, 8'd200, 32'h0); authPulse(1'b1);
    frame(8'h30, 8'd200, 32'h0);
    chk("R8 reauth grant", {memGrant, memDeny}, 2'b10);

    // R7 halt, R3 halted behaviour
    frame(8'h50, 8'h00, 32'h0);
    chk("R7 halted", {61'd0, cardState}, 64'd5);
    frame(8'h26, 8'h00, 32'h0);
    chk("R3 request ignored", {txValid, cardState}, {1'b0, 3'd5});
    frame(8'h93, 8'h20, 32'h0);
    chk("R3 anticoll ignored", {txValid, cardState}, {1'b0, 3'd5});
    frame(8'h52, 8'h00, 32'h0);
    chk("R3 wake", {txValid, txBits, txData[15:0], cardState}, {1'b1, 6'd16, 16'h0002, 3'd1});
    frame(8'h93, 8'h70, ~cardUid);
    chk("R6 fallback halted", 64'(cardState), 64'd5);
    frame(8'h52, 8'h00, 32'h0);
    frame(8'h93, 8'h70, cardUid);
    frame(8'h61, 8'd5, 32'h0);
    authPulse(1'b0);
    chk("R8 fail to halted", 64'(cardState), 64'd5);
    frame(8'h52, 8'h00, 32'h0);
    frame(8'h93, 8'h70, cardUid);
    frame(8'h50, 8'h00, 32'h0);
    chk("R7 halt from active", 64'(cardState), 64'd5);

    // R8 failure from a sleep-woken card
    doReset();
    bringUp();
    frame(8'h60, 8'd9, 32'h0);
    authPulse(1'b0);
    chk("R8 fail to sleep", 64'(cardState), 64'd0);

    // R6 / R10 frame during waiting
    bringUp();
    frame(8'h60, 8'd9, 32'h0);
    frame(8'h30, 8'd9, 32'h0);
    chk("R10 deny in wait", {memGrant, memDeny, cardState}, {2'b01, 3'd0});
    @(negedge clk);
    chk("R12 deny pulse ends", 64'(memDeny), 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule